// File: doc/BRIEF.md
# Glitch-Free Clock Bank Stop Gate

This block switches one bank of output clocks on and off from a single asynchronous, active-low stop request, while every other bank in the chip keeps running. The request is brought into the bank's own free-running source clock domain through a flop synchronizer. The enable that gates the clocks is then re-timed on the falling edge of that source. Because of this, an output can only be parked or released while the source is low. A stopped bank rests at logic 0, and a restarted bank begins with a complete high phase. No runt pulse is produced in either direction.

A power-down hold input overrides the stop request and forces the whole bank low. It travels through the same synchronizer, so it stops the bank on the same glitch-free boundary. A status output shows whether the gate is currently closed. The bank width is a parameter: four for a processor bank, eight for a bus bank. Every output of a bank switches on the same edge.

Top module: `clk_bank_stop`

## Requirements
- R1: A change of `stopN` or `pwrDownHold` made just after source rising edge k first affects the outputs in the high phase that begins at rising edge k+3. This applies with the default of two synchronizer stages.
- R2: Every output is 0 throughout each low phase of the source. While the bank is stopped, every output is also 0 throughout each high phase.
- R3: While the bank runs, each output is 1 for the whole high phase of the source.
- R4: After a stop is requested, the rising edge at which the synchronized control switches (edge k+2) is the last rising edge seen on the outputs.
- R5: When the bank restarts, its first output pulse is high for the full high phase of the source.
- R6: While the synchronized hold is 1, the outputs stay 0 whatever the value of `stopN`. The hold takes effect with the same latency as R1.
- R7: All `BANK_WIDTH` outputs carry the same value at all times.
- R8: `bankStopped` is 1 exactly when the gate is closed. It changes only on a falling edge of the source.
- R9: While `rstN` is 0, the outputs are 0 and `bankStopped` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Free-running source clock of the bank |
| rstN | input | 1 | Asynchronous active-low reset |
| stopN | input | 1 | Asynchronous stop request, 0 stops the bank |
| pwrDownHold | input | 1 | Power-down hold, 1 forces the bank low |
| gatedClk | output | BANK_WIDTH | Gated clock outputs of the bank |
| bankStopped | output | 1 | 1 while the gate is closed |

## Verification
Suppose the enable updated on the rising edge instead of the falling edge. The outputs would then show a shortened high pulse or a sliver, which the samples taken at +1 ns and +3 ns into the high phase catch in the first cycle after a switch. Suppose instead the synchronizer depth or the hold path were wrong. Every output would then start or stop one cycle early or late, and the mismatch appears within one cycle of the first request change. A status output that disagreed with the gate would show up in the very next high-phase sample.

// File: rtl/clk_bank_stop_pkg.sv
package clk_bank_stop_pkg;
  // Strobes from the synchronizing control to the gating datapath.
  typedef struct packed {
    logic gateEn;      // synchronized run request
    logic holdActive;  // synchronized power-down hold
  } gateStrobe_t;
endpackage

// File: rtl/bank_stop_ctrl.sv
module bank_stop_ctrl
  import clk_bank_stop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        srcClk,
  input  logic        rstN,
  input  logic        stopN,
  input  logic        pwrDownHold,
  output gateStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] runSync;
  logic [LAST:0] holdSync;

  // Two parallel synchronizer chains clocked by the free-running source.
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      runSync  <= '0;
      holdSync <= '0;
    end else begin
      runSync  <= {runSync[LAST-1:0], stopN};
      holdSync <= {holdSync[LAST-1:0], pwrDownHold};
    end
  end

  assign strobe.gateEn     = runSync[LAST];
  assign strobe.holdActive = holdSync[LAST];
endmodule

// File: rtl/bank_clk_gate.sv
module bank_clk_gate
  import clk_bank_stop_pkg::*;
#(
  parameter int BANK_WIDTH = 4
) (
  input  logic                  srcClk,
  input  logic                  rstN,
  input  gateStrobe_t           strobe,
  output logic [BANK_WIDTH-1:0] gatedClk,
  output logic                  bankStopped
);
  logic runEn;

  // Enable only moves while the source is low: no runt pulses either way.
  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) runEn <= 1'b0;
    else       runEn <= strobe.gateEn & ~strobe.holdActive;
  end

  for (genvar i = 0; i < BANK_WIDTH; i++) begin : g_bit
    assign gatedClk[i] = srcClk & runEn;
  end

  assign bankStopped = ~runEn;

  AST_PARKED_LOW: assert property (@(posedge srcClk) disable iff (!rstN)
    gatedClk == '0); // R2

  AST_BANK_UNIFORM: assert property (@(negedge srcClk) disable iff (!rstN)
    (gatedClk == '0) || (gatedClk == '1)); // R7

  AST_HOLD_FORCES_LOW: assert property (@(negedge srcClk) disable iff (!rstN)
    $past(strobe.holdActive) |-> gatedClk == '0); // R6

  AST_STATUS_MATCH: assert property (@(negedge srcClk) disable iff (!rstN)
    bankStopped == (gatedClk == '0)); // R8
endmodule

// File: rtl/clk_bank_stop.sv
module clk_bank_stop
  import clk_bank_stop_pkg::*;
#(
  parameter int BANK_WIDTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  srcClk,
  input  logic                  rstN,
  input  logic                  stopN,
  input  logic                  pwrDownHold,
  output logic [BANK_WIDTH-1:0] gatedClk,
  output logic                  bankStopped
);
  gateStrobe_t strobe;

  bank_stop_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .srcClk      (srcClk),
    .rstN        (rstN),
    .stopN       (stopN),
    .pwrDownHold (pwrDownHold),
    .strobe      (strobe)
  );

  bank_clk_gate #(.BANK_WIDTH(BANK_WIDTH)) u_gate (
    .srcClk      (srcClk),
    .rstN        (rstN),
    .strobe      (strobe),
    .gatedClk    (gatedClk),
    .bankStopped (bankStopped)
  );
endmodule

// File: tb/sim_clk_bank_stop.sv
module sim_clk_bank_stop;
  localparam int W   = 4;
  localparam int LAG = 3;   // two sync stages plus the falling-edge re-time

  logic         srcClk = 1'b0;
  logic         rstN = 1'b0;
  logic         stopN = 1'b1;
  logic         pwrDownHold = 1'b0;
  logic [W-1:0] gatedClk;
  logic         bankStopped;

  int  checks = 0;
  int  fails  = 0;
  int  cyc    = -1;
  bit  done   = 0;
  bit  effRun [0:1023];
  bit  effHold[0:1023];

  clk_bank_stop #(.BANK_WIDTH(W), .SYNC_STAGES(2)) u0 (
    .srcClk(srcClk), .rstN(rstN), .stopN(stopN), .pwrDownHold(pwrDownHold),
    .gatedClk(gatedClk), .bankStopped(bankStopped)
  );

  always #4 srcClk = ~srcClk;   // 125 MHz

  function automatic bit expRun(int n);
    return (n >= LAG) ? effRun[n-LAG] : 1'b0;
  endfunction

  function automatic string highTag(int n);
    if (n < LAG + 1) return "R9";
    if (effHold[n-LAG]) return "R6 R1";
    if (expRun(n) && !expRun(n-1)) return "R5 R1 R7";
    if (!expRun(n) && expRun(n-1)) return "R4 R1 R7";
    if (expRun(n)) return "R3 R7";
    return "R2 R7";
  endfunction

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic h, input logic r);
    @(posedge srcClk);
    cyc++;
    #1;
    check(gatedClk, {W{expRun(cyc)}}, highTag(cyc));
    check({{(W-1){1'b0}}, bankStopped}, {{(W-1){1'b0}}, ~expRun(cyc)}, "R8");
    stopN = s; pwrDownHold = h; rstN = r;
    effRun[cyc]  = r & s & ~h;
    effHold[cyc] = r & h;
    #2;
    check(gatedClk, {W{expRun(cyc)}}, highTag(cyc));
    #4;
    check(gatedClk, '0, "R2 R7");
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R9: reset held for several cycles
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b1);
    // single-cycle stop request: exactly one pulse dropped (R4, R5)
    step(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1);
    // long stop then restart
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1);
    // R6: hold while running and while stop is released
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
    // random mix
    begin
      logic s = 1'b1;
      logic h = 1'b0;
      for (int i = 0; i < 300; i++) begin
        if (($urandom % 4) == 0) s = ~s;
        if (($urandom % 8) == 0) h = ~h;
        step(s, h, 1'b1);
      end
    end
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule